// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a general-purpose I/O controller for a parameterised number of pins (default 32). Software reaches it through a single-cycle 32-bit register port. Each pin can be set as an input or an output. Its level can be inverted, and its output value is changed through separate set, clear and toggle registers. Only the pins named by a 1 in the written word change, so software never needs a read-modify-write on the output value.

Input pins pass through a two-stage synchroniser. A rising or falling transition of the polarity-corrected level can raise a per-pin flag. Each pin has its own enable for each edge direction. The flags collect in a sticky status register that is cleared by writing ones to it. A single interrupt output is high while any flag is set. A companion register records, for each pin, whether its most recent captured event was a rising or a falling one.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Registers are selected by `bus_addr` word index: 0 interrupt status (write 1 to clear), 1 last edge kind (read only), 2 rising enable, 3 falling enable, 4 pin level (read only), 5 direction, 6 inversion, 7 output set, 8 output clear, 9 output toggle. Indices 7 to 9 and 10 to 15 read as zero. `bus_rdata` is zero when `bus_sel` is low. Reads are combinational, and a write takes effect at the clock edge where `bus_sel` and `bus_we` are both high.
- R2: Bits at or above NPINS are ignored when written and read back as zero.
- R3: Writing the set register forces each bit written as 1 high in the output value, the clear register forces it low, and the toggle register inverts it. Bits written as 0 keep their value, and the output value changes only through these three registers.
- R4: Direction bit 1 makes a pin an output. `pad_oe` equals the direction register. `pad_out` is the output value XOR inversion for output pins and 0 for input pins. Reading the level register returns the output value, not inverted, for an output pin.
- R5: For an input pin, the level register reads the synchronised pad value XOR its inversion bit. A pad change made before clock edge N is visible after edge N+1.
- R6: An input pin flags an event on a rising transition of its corrected level only when its rising enable is 1, and on a falling transition only when its falling enable is 1. With both enables set it flags either edge, and with both clear it flags none.
- R7: A status bit stays set until a 1 is written to it. Writing back the value just read clears every reported bit and leaves the others unchanged.
- R8: `irq` is high exactly while any status bit is set. A pad edge made before clock edge N sets `irq` after edge N+2.
- R9: In the same cycle that a status bit is set, the edge kind bit of that pin becomes 1 for a rising event and 0 for a falling event. Otherwise it holds.
- R10: An enabled event in the same cycle as a write-one-to-clear of that bit leaves the status bit set.
- R11: After reset all pins are inputs with no inversion, the output value is 0, all enables are 0, and both status registers are 0.
- R12: Pins configured as outputs never flag events. Changing an inversion bit while the pad is steady does not create an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | DATA_W | Write data, one bit per pin |
| bus_rdata | output | DATA_W | Read data for the selected register |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Pad drive levels |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches these properties on every cycle:
- the exact effect of set, clear and toggle writes on the output value, and that the output value holds at all other times;
- that status bits stay set unless cleared;
- that no status bit is set without an enable, or on a pin that was an output;
- the register state after reset.

Some behaviour only the directed scenarios can show. This includes the synchroniser and interrupt latencies counted in edges, the inversion seen on reads, and the edge kind recorded on each event. It also includes a clear that collides with a new edge, partial and read-back clears, and the masking of bits above the pin count, which the bench exercises with a 24-pin instance.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int REG_ADDR_W = 4;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_IRQ_STAT  = 4'd0,
        RA_EDGE_KIND = 4'd1,
        RA_RISE_EN   = 4'd2,
        RA_FALL_EN   = 4'd3,
        RA_LEVEL     = 4'd4,
        RA_DIR       = 4'd5,
        RA_INVERT    = 4'd6,
        RA_OUT_SET   = 4'd7,
        RA_OUT_CLR   = 4'd8,
        RA_OUT_TOG   = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        OUT_HOLD,
        OUT_SET,
        OUT_CLR,
        OUT_TOG
    } out_op_e;

    // One decoded register-port write; at most one field is active.
    typedef struct packed {
        logic    stat_w1c;
        logic    rise_en;
        logic    fall_en;
        logic    dir;
        logic    invert;
        out_op_e out_op;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(
        input logic                  sel,
        input logic                  we,
        input logic [REG_ADDR_W-1:0] addr
    );
        wr_cmd_t c;
        c = '0;
        c.out_op = OUT_HOLD;
        if (sel && we) begin
            case (reg_addr_e'(addr))
                RA_IRQ_STAT: c.stat_w1c = 1'b1;
                RA_RISE_EN:  c.rise_en  = 1'b1;
                RA_FALL_EN:  c.fall_en  = 1'b1;
                RA_DIR:      c.dir      = 1'b1;
                RA_INVERT:   c.invert   = 1'b1;
                RA_OUT_SET:  c.out_op   = OUT_SET;
                RA_OUT_CLR:  c.out_op   = OUT_CLR;
                RA_OUT_TOG:  c.out_op   = OUT_TOG;
                default:     c.out_op   = OUT_HOLD;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    input  logic [NPINS-1:0] wval,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] inv_q,
    output logic [NPINS-1:0] rise_en_q,
    output logic [NPINS-1:0] fall_en_q,
    output logic [NPINS-1:0] out_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q     <= '0;
            inv_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            out_q     <= '0;
        end else begin
            if (cmd.dir)     dir_q     <= wval;
            if (cmd.invert)  inv_q     <= wval;
            if (cmd.rise_en) rise_en_q <= wval;
            if (cmd.fall_en) fall_en_q <= wval;
            case (cmd.out_op)
                OUT_SET: out_q <= out_q | wval;
                OUT_CLR: out_q <= out_q & ~wval;
                OUT_TOG: out_q <= out_q ^ wval;
                default: out_q <= out_q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] level_sync,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] inv,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] stat_q,
    output logic [NPINS-1:0] kind_q
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;
    logic [NPINS-1:0] hit;

    // Both samples are corrected with the current inversion bit, so
    // rewriting the inversion alone never looks like a transition.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic lvl_now;
        logic lvl_was;
        assign lvl_now = level_sync[i] ^ inv[i];
        assign lvl_was = prev_q[i] ^ inv[i];
        assign rise[i] = ~dir[i] & ~lvl_was & lvl_now;
        assign fall[i] = ~dir[i] & lvl_was & ~lvl_now;
        assign hit[i]  = (rise[i] & rise_en[i]) | (fall[i] & fall_en[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
            kind_q <= '0;
        end else begin
            prev_q <= level_sync;
            stat_q <= (stat_q & ~clr_mask) | hit;
            kind_q <= (kind_q & ~hit) | (rise & hit);
        end
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe,
    output logic                  irq
);

    wr_cmd_t          cmd;
    logic [NPINS-1:0] wval;
    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] inv_q;
    logic [NPINS-1:0] ren_q;
    logic [NPINS-1:0] fen_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] stat_q;
    logic [NPINS-1:0] kind_q;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] level_view;
    logic [NPINS-1:0] rd_pins;

    assign cmd      = decode_write(bus_sel, bus_we, bus_addr);
    assign wval     = bus_wdata[NPINS-1:0];
    assign clr_mask = cmd.stat_w1c ? wval : '0;

    gpio_in_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (sync_lvl)
    );

    gpio_cfg_regs #(
        .NPINS (NPINS)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .wval      (wval),
        .dir_q     (dir_q),
        .inv_q     (inv_q),
        .rise_en_q (ren_q),
        .fall_en_q (fen_q),
        .out_q     (out_q)
    );

    gpio_edge_unit #(
        .NPINS (NPINS)
    ) u_edge (
        .clk        (clk),
        .rst        (rst),
        .level_sync (sync_lvl),
        .dir        (dir_q),
        .inv        (inv_q),
        .rise_en    (ren_q),
        .fall_en    (fen_q),
        .clr_mask   (clr_mask),
        .stat_q     (stat_q),
        .kind_q     (kind_q)
    );

    assign level_view = (dir_q & out_q) | (~dir_q & (sync_lvl ^ inv_q));

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_IRQ_STAT:  rd_pins = stat_q;
            RA_EDGE_KIND: rd_pins = kind_q;
            RA_RISE_EN:   rd_pins = ren_q;
            RA_FALL_EN:   rd_pins = fen_q;
            RA_LEVEL:     rd_pins = level_view;
            RA_DIR:       rd_pins = dir_q;
            RA_INVERT:    rd_pins = inv_q;
            default:      rd_pins = '0;
        endcase
        bus_rdata = '0;
        if (bus_sel) begin
            bus_rdata[NPINS-1:0] = rd_pins;
        end
    end

    assign pad_out = (out_q ^ inv_q) & dir_q;
    assign pad_oe  = dir_q;
    assign irq     = |stat_q;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [NPINS-1:0]      dir_q,
    input logic [NPINS-1:0]      inv_q,
    input logic [NPINS-1:0]      ren_q,
    input logic [NPINS-1:0]      fen_q,
    input logic [NPINS-1:0]      out_q,
    input logic [NPINS-1:0]      stat_q
);

    logic             wr_any;
    logic [NPINS-1:0] wmask;
    logic             wr_set;
    logic             wr_clr;
    logic             wr_tog;
    logic             wr_stat;
    logic             rst_d = 1'b0;

    assign wr_any  = bus_sel && bus_we;
    assign wmask   = bus_wdata[NPINS-1:0];
    assign wr_set  = wr_any && (bus_addr == RA_OUT_SET);
    assign wr_clr  = wr_any && (bus_addr == RA_OUT_CLR);
    assign wr_tog  = wr_any && (bus_addr == RA_OUT_TOG);
    assign wr_stat = wr_any && (bus_addr == RA_IRQ_STAT);

    p_set_forces_high_r3: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((out_q & $past(wmask)) == $past(wmask)));

    p_clr_forces_low_r3: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((out_q & $past(wmask)) == '0));

    p_tog_inverts_r3: assert property (@(posedge clk) disable iff (rst)
        wr_tog |=> (out_q == ($past(out_q) ^ $past(wmask))));

    p_out_holds_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_set || wr_clr || wr_tog) |=> $stable(out_q));

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_event_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q) & ~($past(ren_q) | $past(fen_q))) == '0));

    p_output_pin_silent_r12: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q) & $past(dir_q)) == '0));

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            p_reset_state_r11: assert (dir_q == '0 && inv_q == '0 && ren_q == '0 &&
                                       fen_q == '0 && out_q == '0 && stat_q == '0);
        end
    end

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .NPINS  (NPINS),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .dir_q     (dir_q),
    .inv_q     (inv_q),
    .ren_q     (ren_q),
    .fen_q     (fen_q),
    .out_q     (out_q),
    .stat_q    (stat_q)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

    localparam int NP = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    gpio_edge_ctrl #(
        .NPINS  (NP),
        .DATA_W (DW)
    ) i_gpio_edge_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Called just after a falling edge; read path is combinational.
    task automatic bus_peek(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        @(negedge clk);
        bus_peek(a, d);
        chk(req, d, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 16; a++) read_chk("R11 reset register", 4'(a), 32'h0);
        chk("R11 reset pad_oe", 32'(pad_oe), 32'h0);
        chk("R11 reset pad_out", 32'(pad_out), 32'h0);
        chk("R11 reset irq", 32'(irq), 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        bus_write(4'd2, 32'h0000_00A5);
        read_chk("R1 rising enable readback", 4'd2, 32'h0000_00A5);
        bus_write(4'd3, 32'h0012_3400);
        read_chk("R1 falling enable readback", 4'd3, 32'h0012_3400);
        bus_write(4'd5, 32'hFFFF_FFFF);
        read_chk("R2 upper bits of direction", 4'd5, 32'h00FF_FFFF);
        read_chk("R1 set register reads zero", 4'd7, 32'h0);
        read_chk("R1 clear register reads zero", 4'd8, 32'h0);
        read_chk("R1 toggle register reads zero", 4'd9, 32'h0);
        read_chk("R1 unmapped index reads zero", 4'd12, 32'h0);
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = 4'd5; #1;
        chk("R1 rdata zero without select", bus_rdata, 32'h0);
        bus_write(4'd2, 32'h0);
        bus_write(4'd3, 32'h0);
        bus_write(4'd5, 32'h0);
        @(negedge clk);
        bus_peek(4'd5, d);
        chk("R1 direction cleared", d, 32'h0);
    endtask

    task automatic t_outputs;
        bus_write(4'd5, 32'h0000_00FF);
        chk("R4 pad_oe follows direction", 32'(pad_oe), 32'h0000_00FF);
        bus_write(4'd7, 32'h0000_000F);
        chk("R3 set drives bits high", 32'(pad_out), 32'h0000_000F);
        bus_write(4'd8, 32'h0000_0003);
        chk("R3 clear drives bits low", 32'(pad_out), 32'h0000_000C);
        bus_write(4'd9, 32'h0000_0081);
        chk("R3 toggle inverts bits", 32'(pad_out), 32'h0000_008D);
        bus_write(4'd4, 32'h0000_00FF);
        chk("R3 level write has no effect", 32'(pad_out), 32'h0000_008D);
        read_chk("R4 level of output pins", 4'd4, 32'h0000_008D);
        bus_write(4'd6, 32'h0000_0001);
        chk("R4 inversion on output pad", 32'(pad_out), 32'h0000_008C);
        read_chk("R4 level not inverted for output", 4'd4, 32'h0000_008D);
        bus_write(4'd8, 32'hFFFF_FFFF);
        bus_write(4'd5, 32'h0);
        bus_write(4'd6, 32'h0);
        chk("R4 pad_out zero for inputs", 32'(pad_out), 32'h0);
        chk("R4 pad_oe cleared", 32'(pad_oe), 32'h0);
    endtask

    task automatic t_input_sync;
        logic [31:0] d;
        bus_write(4'd6, 32'h0000_0100);
        read_chk("R5 inverted idle input", 4'd4, 32'h0000_0100);
        @(negedge clk);
        pad_in = 24'h000300;
        @(negedge clk);
        bus_peek(4'd4, d);
        chk("R5 level after one edge unchanged", d, 32'h0000_0100);
        @(negedge clk);
        bus_peek(4'd4, d);
        chk("R5 level after two edges", d, 32'h0000_0200);
        pad_in = '0;
        bus_write(4'd6, 32'h0);
        wait_cyc(4);
    endtask

    task automatic t_edges;
        bus_write(4'd2, 32'h0000_0005);
        bus_write(4'd3, 32'h0000_0006);
        @(negedge clk);
        pad_in = 24'h00000F;
        @(negedge clk);
        @(negedge clk);
        chk("R8 irq low two edges after pad change", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R8 irq high three edges after pad change", 32'(irq), 32'h1);
        read_chk("R6 rising events by enable", 4'd0, 32'h0000_0005);
        read_chk("R9 kind marks rising", 4'd1, 32'h0000_0005);
        bus_write(4'd0, 32'h0000_0005);
        read_chk("R7 write one clears", 4'd0, 32'h0);
        chk("R8 irq drops when status empty", 32'(irq), 32'h0);
        @(negedge clk);
        pad_in = '0;
        wait_cyc(4);
        read_chk("R6 falling events by enable", 4'd0, 32'h0000_0006);
        read_chk("R9 kind marks falling", 4'd1, 32'h0000_0001);
        wait_cyc(5);
        read_chk("R7 status stays set", 4'd0, 32'h0000_0006);
    endtask

    task automatic t_clear_modes;
        logic [31:0] d;
        bus_write(4'd0, 32'h0000_0002);
        read_chk("R7 partial clear", 4'd0, 32'h0000_0004);
        chk("R8 irq while one bit remains", 32'(irq), 32'h1);
        @(negedge clk);
        bus_peek(4'd0, d);
        bus_write(4'd0, d);
        read_chk("R7 write back read value clears", 4'd0, 32'h0);
        chk("R8 irq low after read-back clear", 32'(irq), 32'h0);
    endtask

    task automatic t_collision;
        @(negedge clk);
        pad_in = 24'h000004;
        wait_cyc(4);
        read_chk("R6 both enables catch rise", 4'd0, 32'h0000_0004);
        @(negedge clk);
        pad_in = '0;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0000_0004;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        read_chk("R10 clear colliding with edge keeps bit", 4'd0, 32'h0000_0004);
        read_chk("R9 kind updated on collision", 4'd1, 32'h0000_0001);
        bus_write(4'd0, 32'h0000_0004);
        read_chk("R10 later clear succeeds", 4'd0, 32'h0);
    endtask

    task automatic t_silent_cases;
        bus_write(4'd5, 32'h0000_0010);
        bus_write(4'd2, 32'h0000_0015);
        bus_write(4'd3, 32'h0000_0016);
        @(negedge clk);
        pad_in = 24'h000010;
        wait_cyc(4);
        pad_in = '0;
        wait_cyc(4);
        read_chk("R12 output pin raises no event", 4'd0, 32'h0);
        bus_write(4'd6, 32'h0000_0004);
        wait_cyc(4);
        read_chk("R12 inversion change raises no event", 4'd0, 32'h0);
        chk("R12 irq stays low", 32'(irq), 32'h0);
        bus_write(4'd6, 32'h0);
        bus_write(4'd0, 32'hFF00_0000);
        read_chk("R2 write above pin count ignored", 4'd0, 32'h0);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_outputs();
        t_input_sync();
        t_edges();
        t_clear_modes();
        t_collision();
        t_silent_cases();
        report();
        $finish;
    end

endmodule